// File: doc/BRIEF.md
# Nibble-Encoded Accumulator Processor Core

This block is a small 8-bit accumulator machine. Every instruction occupies a single byte of a 16-entry memory that holds both code and data. The upper four bits of the byte choose the operation, and the lower four bits give a direct memory address. The core can load a memory byte into the accumulator, add a memory byte to the accumulator, store the accumulator back to memory, and halt. It runs each instruction in three fixed steps. First it latches the fetched byte into an instruction register. Next it reads the addressed operand. Last it performs the operation.

Programs enter the core through a load port that writes memory only while the synchronous reset is asserted. Once reset is released, execution starts at address 0. The accumulator, the program counter, the instruction register and a halted flag are driven to output ports so that the core's progress can be watched from outside.

Top module: `nib_acc_core`

## Requirements
- R1: An instruction byte carries the operation code in bits 7..4 and a direct address (0 to 15) in bits 3..0. The fetched byte appears on `ir_o` on the cycle after the fetch step.
- R2: While `rst` is high at a clock edge, the accumulator, program counter, instruction register and halted flag are cleared. Memory contents are kept. After `rst` is released, the first fetch reads address 0.
- R3: A write through the load port (`ld_en`, `ld_addr`, `ld_data`) changes memory only at edges where `rst` is high. While the core is running, the load port has no effect.
- R4: Code 0x1 copies the byte at the addressed location into the accumulator.
- R5: Code 0x2 adds the byte at the addressed location to the accumulator modulo 256, and the carry is dropped.
- R6: Code 0x3 writes the accumulator to the addressed location. The next instruction sees the new value, both when it fetches from that location and when it reads it as an operand.
- R7: Code 0xF sets `halted_o` in its execute step, whatever its address field holds. After that, the accumulator, program counter, instruction register, halted flag and memory stay unchanged until reset.
- R8: Codes 0x0 and 0x4 through 0xE change nothing except the program counter.
- R9: Every instruction takes exactly three cycles. The program counter goes up by one at the fetch edge only, and the accumulator changes only at the execute edge.
- R10: The 4-bit program counter wraps from 15 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| ld_en | input | 1 | Memory write strobe of the load port, acted on only during reset |
| ld_addr | input | 4 | Memory location written by the load port |
| ld_data | input | 8 | Byte written by the load port |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 4 | Program counter (address of the next fetch) |
| ir_o | output | 8 | Instruction register |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
Two situations are hard to reach from the ports. One is a store whose result is consumed by the very next instruction. The other is a store that rewrites code which the core then fetches. Both are reached with short programs: in one, a STORE is followed at once by a LOAD of the same location; in the other, a STORE overwrites the next instruction with a halt byte, so a stale read would leave the core running. Program-counter wrap and the load port being ignored are reached with a memory filled with no-operation codes. While that program runs, the load port drives a halt byte toward address 0, and the bench watches the byte fetched after the counter wraps. A behavioural reference model follows every clock.

// File: rtl/nac_pkg.sv
package nac_pkg;

  // Instruction-set constants: the opcode field is always four bits wide.
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  // One-hot step of the instruction cycle.
  typedef enum logic [2:0] {
    PH_FETCH  = 3'b001,
    PH_DECODE = 3'b010,
    PH_EXEC   = 3'b100
  } nac_phase_e;

  // Decoded operation class.
  typedef enum logic [2:0] {
    K_NOP   = 3'd0,
    K_LOAD  = 3'd1,
    K_ADD   = 3'd2,
    K_STORE = 3'd3,
    K_HALT  = 3'd4
  } nac_kind_e;

  function automatic nac_kind_e classify(input logic [OPC_W-1:0] opc);
    nac_kind_e k;
    case (opc)
      OPC_LOAD:  k = K_LOAD;
      OPC_ADD:   k = K_ADD;
      OPC_STORE: k = K_STORE;
      OPC_HALT:  k = K_HALT;
      default:   k = K_NOP;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/nac_mem.sv
module nac_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // One write-enabled register per location; no reset so loaded code survives.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic sel;
    assign sel = we_i && (waddr_i == ADDR_W'(gi));
    always_ff @(posedge clk) begin
      if (sel) cells[gi] <= wdata_i;
    end
  end

  // Asynchronous read keeps a just-written byte visible on the next cycle.
  assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/nac_ctrl.sv
module nac_ctrl
  import nac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc_i,
  output logic [2:0]       phase_o,
  output logic             fetch_evt_o,
  output logic             decode_evt_o,
  output logic             load_evt_o,
  output logic             add_evt_o,
  output logic             store_evt_o,
  output logic             halted_o
);

  nac_phase_e phase_q;
  nac_kind_e  kind_q;
  logic       halted_q;
  logic       running;

  assign running = !rst && !halted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_FETCH;
      kind_q   <= K_NOP;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      case (phase_q)
        PH_FETCH:  phase_q <= PH_DECODE;
        PH_DECODE: begin
          kind_q  <= classify(opc_i);
          phase_q <= PH_EXEC;
        end
        PH_EXEC: begin
          if (kind_q == K_HALT) halted_q <= 1'b1;
          else                  phase_q  <= PH_FETCH;
        end
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  logic in_exec;
  assign in_exec = running && (phase_q == PH_EXEC);

  assign phase_o      = phase_q;
  assign fetch_evt_o  = running && (phase_q == PH_FETCH);
  assign decode_evt_o = running && (phase_q == PH_DECODE);
  assign load_evt_o   = in_exec && (kind_q == K_LOAD);
  assign add_evt_o    = in_exec && (kind_q == K_ADD);
  assign store_evt_o  = in_exec && (kind_q == K_STORE);
  assign halted_o     = halted_q;

endmodule

// File: rtl/nac_dp.sv
module nac_dp #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_evt_i,
  input  logic              decode_evt_i,
  input  logic              load_evt_i,
  input  logic              add_evt_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] opnd_o
);

  logic [DATA_W-1:0] acc_q, ir_q, opnd_q;
  logic [ADDR_W-1:0] pc_q;

  // Sum kept to the accumulator width: the carry is discarded.
  function automatic logic [DATA_W-1:0] wrap_sum(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DATA_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] next_pc(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      pc_q   <= '0;
      ir_q   <= '0;
      opnd_q <= '0;
    end else begin
      if (fetch_evt_i) begin
        ir_q <= rdata_i;
        pc_q <= next_pc(pc_q);
      end
      if (decode_evt_i) opnd_q <= rdata_i;
      if (load_evt_i)      acc_q <= opnd_q;
      else if (add_evt_i)  acc_q <= wrap_sum(acc_q, opnd_q);
    end
  end

  assign acc_o  = acc_q;
  assign pc_o   = pc_q;
  assign ir_o   = ir_q;
  assign opnd_o = opnd_q;

endmodule

// File: rtl/nib_acc_core.sv
module nib_acc_core
  import nac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_en,
  input  logic [DATA_W-OPC_W-1:0]   ld_addr,
  input  logic [DATA_W-1:0]         ld_data,
  output logic [DATA_W-1:0]         acc_o,
  output logic [DATA_W-OPC_W-1:0]   pc_o,
  output logic [DATA_W-1:0]         ir_o,
  output logic                      halted_o
);

  localparam int ADDR_W = DATA_W - OPC_W;

  logic [2:0]        phase_vec;
  logic              fetch_evt, decode_evt, load_evt, add_evt, store_evt;
  logic [DATA_W-1:0] acc, ir, opnd_q, rdata;
  logic [ADDR_W-1:0] pc, raddr, waddr;
  logic [DATA_W-1:0] wdata;
  logic              mem_we;
  logic [OPC_W-1:0]  ir_opc;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_opc  = ir[DATA_W-1 -: OPC_W];
  assign ir_addr = ir[ADDR_W-1:0];

  nac_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .opc_i        (ir_opc),
    .phase_o      (phase_vec),
    .fetch_evt_o  (fetch_evt),
    .decode_evt_o (decode_evt),
    .load_evt_o   (load_evt),
    .add_evt_o    (add_evt),
    .store_evt_o  (store_evt),
    .halted_o     (halted_o)
  );

  nac_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .fetch_evt_i  (fetch_evt),
    .decode_evt_i (decode_evt),
    .load_evt_i   (load_evt),
    .add_evt_i    (add_evt),
    .rdata_i      (rdata),
    .acc_o        (acc),
    .pc_o         (pc),
    .ir_o         (ir),
    .opnd_o       (opnd_q)
  );

  // Read port: program counter during fetch, operand address otherwise.
  assign raddr = phase_vec[0] ? pc : ir_addr;

  // Write port: loader while held in reset, STORE execution while running.
  assign mem_we = rst ? ld_en   : store_evt;
  assign waddr  = rst ? ld_addr : ir_addr;
  assign wdata  = rst ? ld_data : acc;

  nac_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign acc_o = acc;
  assign pc_o  = pc;
  assign ir_o  = ir;

endmodule

// File: rtl/nac_core_chk.sv
module nac_core_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] ir_o,
  input logic              halted_o,
  input logic              fetch_evt,
  input logic              add_evt,
  input logic              mem_we,
  input logic [DATA_W-1:0] opnd_q,
  input logic [2:0]        phase_vec
);

  localparam int OW = DATA_W - ADDR_W;

  // R2: the first cycle after reset shows a cleared core
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_o == '0 && pc_o == '0 && ir_o == '0 && !halted_o));

  // R5: ADD result is the wrapped sum of accumulator and operand
  p_wrap_add_r5: assert property (@(posedge clk) disable iff (rst)
    add_evt |=> (acc_o == DATA_W'($past(acc_o) + $past(opnd_q))));

  // R6: a running memory write only comes from an executing STORE
  p_store_only_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ir_o[DATA_W-1 -: OW] == OW'(3) && phase_vec == 3'b100));

  // R7: once halted, the visible state is frozen
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> (halted_o && $stable(acc_o) && $stable(pc_o) && $stable(ir_o)));

  // R9: exactly one step of the instruction cycle is active
  p_phase_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_vec) == 1);

  // R9: the program counter moves only after a fetch, and by one
  p_pc_fetch_only_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fetch_evt)) |-> $stable(pc_o));

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fetch_evt)) |-> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

endmodule

bind nib_acc_core nac_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_o     (acc_o),
  .pc_o      (pc_o),
  .ir_o      (ir_o),
  .halted_o  (halted_o),
  .fetch_evt (fetch_evt),
  .add_evt   (add_evt),
  .mem_we    (mem_we),
  .opnd_q    (opnd_q),
  .phase_vec (phase_vec)
);

// File: tb/test_nib_acc_core.sv
`timescale 1ns/1ps
module test_nib_acc_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] acc_o, ir_o;
  logic [3:0] pc_o;
  logic       halted_o;

  always #2 clk = ~clk;  // 250 MHz

  nib_acc_core i_nib_acc_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .acc_o(acc_o), .pc_o(pc_o), .ir_o(ir_o), .halted_o(halted_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_req = "R2";

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mem[16];
  int m_acc, m_pc, m_ir, m_step;
  bit m_halt;

  always @(posedge clk) begin
    if (rst) begin
      if (ld_en) m_mem[ld_addr] = ld_data;
      m_acc = 0; m_pc = 0; m_ir = 0; m_halt = 0; m_step = 0;
    end else if (!m_halt) begin
      if (m_step == 0) begin
        m_ir = m_mem[m_pc];
        m_pc = (m_pc + 1) % 16;
      end else if (m_step == 2) begin
        case (m_ir / 16)
          1:  m_acc = m_mem[m_ir % 16];
          2:  m_acc = (m_acc + m_mem[m_ir % 16]) % 256;
          3:  m_mem[m_ir % 16] = m_acc;
          15: m_halt = 1;
          default: ;
        endcase
      end
      if (!m_halt) m_step = (m_step + 1) % 3;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_chk++;
      if (acc_o != m_acc[7:0] || pc_o != m_pc[3:0] || ir_o != m_ir[7:0] || halted_o != m_halt) begin
        n_fail++;
        $display("FAIL %s: actual acc=%0h pc=%0h ir=%0h h=%0b expected acc=%0h pc=%0h ir=%0h h=%0b",
                 cur_req, acc_o, pc_o, ir_o, halted_o, m_acc, m_pc, m_ir, m_halt);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_prog(input logic [7:0] img [16]);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ld_en = 1'b1; ld_addr = 4'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R2: state cleared while in reset, still cleared before the first run edge
    check("R2", acc_o, 0); check("R2", pc_o, 0);
    check("R2", ir_o, 0);  check("R2", halted_o, 0);
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 200 && !halted_o; i++) @(negedge clk);
  endtask

  logic [7:0] img [16];

  initial begin
    // ---- program A: load, add, store then reload of the stored value ----
    foreach (img[i]) img[i] = 8'h00;
    img[0] = 8'h1E; img[1] = 8'h2F; img[2] = 8'h3D; img[3] = 8'h1D;
    img[4] = 8'h2D; img[5] = 8'h50; img[6] = 8'hF3;
    img[14] = 8'h05; img[15] = 8'h07;
    load_prog(img);
    cmp_on = 1; cur_req = "R9";
    tick(1); check("R1", ir_o, 8'h1E); check("R9", pc_o, 1);
    tick(1); check("R9", pc_o, 1); check("R9", acc_o, 0);
    tick(1); check("R4", acc_o, 5); check("R9", pc_o, 1);
    tick(1); check("R9", pc_o, 2); check("R1", ir_o, 8'h2F);
    cur_req = "R6";
    run_to_halt();
    check("R6", acc_o, 24);
    check("R7", halted_o, 1);
    check("R7", pc_o, 7);
    tick(12);
    check("R7", acc_o, 24); check("R7", pc_o, 7); check("R7", ir_o, 8'hF3);

    // ---- program B: ADD that overflows 8 bits ----
    cmp_on = 0; cur_req = "R5";
    foreach (img[i]) img[i] = 8'h00;
    img[0] = 8'h1E; img[1] = 8'h2F; img[2] = 8'hF0;
    img[14] = 8'hC8; img[15] = 8'h64;
    load_prog(img);
    cmp_on = 1;
    run_to_halt();
    check("R5", acc_o, 8'h2C);
    check("R7", pc_o, 3);

    // ---- program C: STORE rewrites the next instruction into a halt ----
    cmp_on = 0; cur_req = "R6";
    foreach (img[i]) img[i] = 8'h00;
    img[0] = 8'h1E; img[1] = 8'h32; img[2] = 8'h2E; img[3] = 8'h2E;
    img[14] = 8'hF0;
    load_prog(img);
    cmp_on = 1;
    tick(20);
    check("R6", halted_o, 1); check("R6", ir_o, 8'hF0);
    check("R6", acc_o, 8'hF0); check("R6", pc_o, 3);

    // ---- program D: no-operations only, loader active during run ----
    cmp_on = 0; cur_req = "R8";
    for (int i = 0; i < 16; i++) begin
      int k;
      k = i % 12;
      img[i] = {(k == 0) ? 4'h0 : 4'(k + 3), 4'(i)};
    end
    load_prog(img);
    cmp_on = 1;
    tick(10);
    ld_en = 1'b1; ld_addr = 4'h0; ld_data = 8'hF0;
    tick(6);
    ld_en = 1'b0;
    tick(32);  // 48 edges: sixteen instructions
    check("R10", pc_o, 0);
    check("R8", acc_o, 0);
    tick(1);
    cur_req = "R3";
    check("R3", ir_o, 8'h00);
    check("R10", pc_o, 1);
    tick(2);
    check("R3", halted_o, 0);
    tick(40);
    check("R8", acc_o, 0); check("R8", halted_o, 0);

    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule